// File: doc/BRIEF.md
# Compact Jump-Register Unit with Hazard Barrier

This block executes a single 32-bit register-indirect call instruction that has no delay slot and also works as a hazard barrier. When a matching instruction is issued, the block captures the target register value on the same cycle. One cycle later it produces a link write of the jump's own address plus four and a squash pulse for the sequentially following instruction. It then stalls issue and raises a flush request until every outstanding system-state write has drained. After that it emits a single redirect. The redirect carries the target address with bit 0 cleared, the new instruction-set mode, and an address-error tag that the fetch stage raises when it fetches the target.

A build-time parameter says whether the word-aligned 32-bit instruction set is supported. When it is, the mode follows bit 0 of the target. When it is not, an even target is always tagged as an error. An encoding that does not match the fixed fields produces a reserved-instruction pulse and nothing else.

Top module: `jrhb_unit`

## Requirements
- R1: An instruction matches only when bits [31:26] are 000000, bits [10:6] and [15:11] together (bits [15:6]) are 0001111100, and bits [5:0] are 111100. An accepted non-matching word pulses `rsvd_instr` for one cycle, one cycle after issue, with no `wb_en`, no `squash_next`, no flush and no redirect.
- R2: One cycle after a matching instruction is accepted, `wb_data` equals `instr_pc + 4` and `wb_idx` equals the rt field, bits [25:21].
- R3: `wb_en` pulses with the link data unless rt is 0, in which case no write is issued.
- R4: The target is taken from `rs_value` in the issue cycle, where `rs_sel` shows bits [20:16]. Later changes to `rs_value`, including the link write when rt equals rs, do not alter the redirect.
- R5: `squash_next` pulses for exactly one cycle, one cycle after every accepted matching instruction.
- R6: With the word ISA supported, `redir_mode` equals bit 0 of the target and `redir_addr` equals the target with bit 0 cleared.
- R7: With the word ISA supported, `redir_addr_err` is set exactly when target bit 0 is 0 and bit 1 is 1.
- R8: With the word ISA not supported, `redir_mode` is 1 and `redir_addr_err` equals the inverse of target bit 0.
- R9: `flush_req` is high from the cycle after acceptance until the redirect cycle. While `sys_wr_busy` is sampled high, no redirect is issued.
- R10: The redirect is a single-cycle `redir_valid` pulse. It appears in the cycle after the first clock edge at which `sys_wr_busy` is sampled low during the wait.
- R11: `ready` is low while the barrier waits, and instructions offered then are ignored. `ready` is high in the redirect cycle, so an instruction offered in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered this cycle |
| instr_word | input | 32 | Instruction encoding |
| instr_pc | input | 32 | Address of the offered instruction |
| rs_sel | output | 5 | Register index to read for the target |
| rs_value | input | 32 | Value of the register named by `rs_sel` |
| sys_wr_busy | input | 1 | System-state writes still outstanding |
| ready | output | 1 | Block accepts an instruction this cycle |
| rsvd_instr | output | 1 | Reserved-instruction pulse |
| wb_en | output | 1 | Link write enable |
| wb_idx | output | 5 | Link destination register |
| wb_data | output | 32 | Link value |
| squash_next | output | 1 | Kill the sequentially following instruction |
| flush_req | output | 1 | Barrier waiting for writes to drain |
| redir_valid | output | 1 | Redirect pulse to fetch |
| redir_addr | output | 32 | Redirect address, bit 0 clear |
| redir_mode | output | 1 | New instruction-set mode |
| redir_addr_err | output | 1 | Raise address error when the target is fetched |

## Verification
The barrier release and a fresh issue can land in the same cycle. In the redirect cycle `ready` has already returned high, so a second jump offered there must be accepted while the first redirect leaves. A jump offered one cycle earlier, while busy still holds the barrier, must vanish without trace. The bench provokes both cases by dropping `sys_wr_busy` after a multi-cycle hold and then offering jumps on both sides of the release. A behavioural model decides every cycle which instruction was accepted and which redirect is due, and it compares the full payload of both.

// File: rtl/jrhb_pkg.sv
package jrhb_pkg;
  localparam int unsigned JR_XLEN   = 32;
  localparam int unsigned JR_IW     = 32;
  localparam int unsigned JR_RIDX_W = 5;

  localparam logic [5:0] JR_MAJOR = 6'b000000;
  localparam logic [9:0] JR_FUNC  = 10'b0001111100;
  localparam logic [5:0] JR_MINOR = 6'b111100;

  typedef enum logic {BAR_IDLE = 1'b0, BAR_WAIT = 1'b1} bar_state_t;
endpackage

// File: rtl/jrhb_decode.sv
module jrhb_decode
  import jrhb_pkg::*;
#(
  parameter int unsigned IW = JR_IW,
  parameter int unsigned RW = JR_RIDX_W
) (
  input  logic [IW-1:0] word,
  output logic          match,
  output logic [RW-1:0] rt_idx,
  output logic [RW-1:0] rs_idx
);
  localparam int unsigned RT_LSB = IW - 6 - RW;
  localparam int unsigned RS_LSB = RT_LSB - RW;

  logic major_ok, func_ok, minor_ok;

  always_comb begin
    major_ok = (word[IW-1 -: 6] == JR_MAJOR);
    func_ok  = (word[15:6] == JR_FUNC);
    minor_ok = (word[5:0] == JR_MINOR);
    match    = major_ok && func_ok && minor_ok;
    rt_idx   = word[RT_LSB +: RW];
    rs_idx   = word[RS_LSB +: RW];
  end
endmodule

// File: rtl/jrhb_target.sv
module jrhb_target
  import jrhb_pkg::*;
#(
  parameter int unsigned XLEN        = JR_XLEN,
  parameter bit          CLASSIC_ISA = 1'b1
) (
  input  logic [XLEN-1:0] tgt_in,
  output logic [XLEN-1:0] tgt_addr,
  output logic            tgt_mode,
  output logic            tgt_err
);
  always_comb tgt_addr = {tgt_in[XLEN-1:1], 1'b0};

  generate
    if (CLASSIC_ISA) begin : g_word_isa
      always_comb begin
        tgt_mode = tgt_in[0];
        tgt_err  = !tgt_in[0] && tgt_in[1];
      end
    end else begin : g_compact_only
      always_comb begin
        tgt_mode = 1'b1;
        tgt_err  = !tgt_in[0];
      end
    end
  endgenerate
endmodule

// File: rtl/jrhb_barrier.sv
module jrhb_barrier
  import jrhb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy,
  output logic pending,
  output logic fire
);
  bar_state_t state;
  logic       fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= BAR_IDLE;
      fire_q <= 1'b0;
    end else begin
      fire_q <= (state == BAR_WAIT) && !busy;
      case (state)
        BAR_IDLE: if (start) state <= BAR_WAIT;
        BAR_WAIT: if (!busy) state <= BAR_IDLE;
        default:  state <= BAR_IDLE;
      endcase
    end
  end

  always_comb begin
    pending = (state == BAR_WAIT);
    fire    = fire_q;
  end

  AST_NO_FIRE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> !$past(busy)); // R9
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q); // R10
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start && !pending) |=> pending); // R9
endmodule

// File: rtl/jrhb_unit.sv
module jrhb_unit
  import jrhb_pkg::*;
#(
  parameter int unsigned XLEN        = JR_XLEN,
  parameter int unsigned RW          = JR_RIDX_W,
  parameter bit          CLASSIC_ISA = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [31:0]     instr_word,
  input  logic [XLEN-1:0] instr_pc,
  output logic [RW-1:0]   rs_sel,
  input  logic [XLEN-1:0] rs_value,
  input  logic            sys_wr_busy,
  output logic            ready,
  output logic            rsvd_instr,
  output logic            wb_en,
  output logic [RW-1:0]   wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            squash_next,
  output logic            flush_req,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_addr,
  output logic            redir_mode,
  output logic            redir_addr_err
);
  localparam logic [XLEN-1:0] LINK_STEP = XLEN'(4);

  logic            dec_match;
  logic [RW-1:0]   dec_rt, dec_rs;
  logic [XLEN-1:0] t_addr;
  logic            t_mode, t_err;
  logic            bar_pending, bar_fire;
  logic            take, accept_ok, accept_bad;

  jrhb_decode #(.IW(32), .RW(RW)) u_dec (
    .word   (instr_word),
    .match  (dec_match),
    .rt_idx (dec_rt),
    .rs_idx (dec_rs)
  );

  jrhb_target #(.XLEN(XLEN), .CLASSIC_ISA(CLASSIC_ISA)) u_tgt (
    .tgt_in   (rs_value),
    .tgt_addr (t_addr),
    .tgt_mode (t_mode),
    .tgt_err  (t_err)
  );

  always_comb begin
    rs_sel     = dec_rs;
    ready      = !bar_pending;
    take       = instr_valid && ready;
    accept_ok  = take && dec_match;
    accept_bad = take && !dec_match;
  end

  jrhb_barrier u_bar (
    .clk     (clk),
    .rst     (rst),
    .start   (accept_ok),
    .busy    (sys_wr_busy),
    .pending (bar_pending),
    .fire    (bar_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsvd_instr     <= 1'b0;
      wb_en          <= 1'b0;
      wb_idx         <= '0;
      wb_data        <= '0;
      squash_next    <= 1'b0;
      redir_addr     <= '0;
      redir_mode     <= 1'b0;
      redir_addr_err <= 1'b0;
    end else begin
      rsvd_instr  <= accept_bad;
      wb_en       <= accept_ok && (dec_rt != '0);
      squash_next <= accept_ok;
      if (accept_ok) begin
        wb_idx         <= dec_rt;
        wb_data        <= instr_pc + LINK_STEP;
        redir_addr     <= t_addr;
        redir_mode     <= t_mode;
        redir_addr_err <= t_err;
      end
    end
  end

  always_comb begin
    flush_req   = bar_pending;
    redir_valid = bar_fire;
  end

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsvd_instr |-> (!wb_en && !squash_next)); // R1
  AST_LINK_SQUASH: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> squash_next); // R5
  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    (squash_next && wb_idx == '0) |-> !wb_en); // R3
  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(flush_req && redir_valid)); // R9
  AST_ALIGN_BIT0: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> !redir_addr[0]); // R6
  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (flush_req && $past(flush_req)) |-> $stable(redir_addr)); // R4
endmodule

// File: tb/jrhb_unit_test.sv
module jrhb_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [31:0] instr_word, instr_pc, rs_value;
  logic        sys_wr_busy;

  logic [4:0]  rs_sel    [2];
  logic        ready     [2];
  logic        rsvd      [2];
  logic        wb_en     [2];
  logic [4:0]  wb_idx    [2];
  logic [31:0] wb_data   [2];
  logic        squash    [2];
  logic        flush     [2];
  logic        rv        [2];
  logic [31:0] ra        [2];
  logic        rm        [2];
  logic        re        [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  jrhb_unit #(.CLASSIC_ISA(1'b1)) uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_pc(instr_pc), .rs_sel(rs_sel[0]), .rs_value(rs_value),
    .sys_wr_busy(sys_wr_busy), .ready(ready[0]), .rsvd_instr(rsvd[0]),
    .wb_en(wb_en[0]), .wb_idx(wb_idx[0]), .wb_data(wb_data[0]),
    .squash_next(squash[0]), .flush_req(flush[0]), .redir_valid(rv[0]),
    .redir_addr(ra[0]), .redir_mode(rm[0]), .redir_addr_err(re[0]));

  jrhb_unit #(.CLASSIC_ISA(1'b0)) uut_nc (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_pc(instr_pc), .rs_sel(rs_sel[1]), .rs_value(rs_value),
    .sys_wr_busy(sys_wr_busy), .ready(ready[1]), .rsvd_instr(rsvd[1]),
    .wb_en(wb_en[1]), .wb_idx(wb_idx[1]), .wb_data(wb_data[1]),
    .squash_next(squash[1]), .flush_req(flush[1]), .redir_valid(rv[1]),
    .redir_addr(ra[1]), .redir_mode(rm[1]), .redir_addr_err(re[1]));

  // behavioural reference state, index 0 = word ISA present, 1 = absent
  bit          m_pend [2];
  logic [31:0] m_tgt  [2];
  bit m_rsvd[2], m_wb[2], m_sq[2], m_rv[2];
  logic [4:0]  m_idx  [2];
  logic [31:0] m_data [2];

  function automatic logic [31:0] enc(input logic [4:0] rt, input logic [4:0] rs);
    return {6'b000000, rt, rs, 10'b0001111100, 6'b111100};
  endfunction

  task automatic chk(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst%0d at %0t: actual %h expected %h", tag, k, $time, act, exp);
    end
  endtask

  task automatic model_step();
    for (int k = 0; k < 2; k++) begin
      bit rdy, ok;
      m_rsvd[k] = 0; m_wb[k] = 0; m_sq[k] = 0; m_rv[k] = 0;
      if (rst) begin
        m_pend[k] = 0; m_idx[k] = 0; m_data[k] = 0; m_tgt[k] = 0;
      end else begin
        rdy = !m_pend[k];
        if (m_pend[k] && !sys_wr_busy) begin
          m_rv[k] = 1; m_pend[k] = 0;
        end
        if (rdy && instr_valid) begin
          ok = (instr_word[31:26] == 6'd0) && (instr_word[15:6] == 10'h07C) &&
               (instr_word[5:0] == 6'h3C);
          if (ok) begin
            m_idx[k]  = instr_word[25:21];
            m_data[k] = instr_pc + 32'd4;
            m_wb[k]   = (instr_word[25:21] != 5'd0);
            m_sq[k]   = 1;
            m_tgt[k]  = rs_value;
            m_pend[k] = 1;
          end else m_rsvd[k] = 1;
        end
      end
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      logic [31:0] xa; logic xm, xe;
      xa = {m_tgt[k][31:1], 1'b0};
      xm = (k == 0) ? m_tgt[k][0] : 1'b1;
      xe = (k == 0) ? (!m_tgt[k][0] && m_tgt[k][1]) : !m_tgt[k][0];
      chk("R4 rs_sel", k, 32'(rs_sel[k]), 32'(instr_word[20:16]));
      chk("R1 rsvd_instr", k, 32'(rsvd[k]), 32'(m_rsvd[k]));
      chk("R3 wb_en", k, 32'(wb_en[k]), 32'(m_wb[k]));
      chk("R5 squash_next", k, 32'(squash[k]), 32'(m_sq[k]));
      chk("R9 flush_req", k, 32'(flush[k]), 32'(m_pend[k]));
      chk("R11 ready", k, 32'(ready[k]), 32'(!m_pend[k]));
      chk("R10 redir_valid", k, 32'(rv[k]), 32'(m_rv[k]));
      if (m_wb[k]) begin
        chk("R2 wb_idx", k, 32'(wb_idx[k]), 32'(m_idx[k]));
        chk("R2 wb_data", k, wb_data[k], m_data[k]);
      end
      if (m_rv[k]) begin
        chk("R4/R6 redir_addr", k, ra[k], xa);
        chk(k == 0 ? "R6 redir_mode" : "R8 redir_mode", k, 32'(rm[k]), 32'(xm));
        chk(k == 0 ? "R7 redir_addr_err" : "R8 redir_addr_err", k, 32'(re[k]), 32'(xe));
      end
    end
  endtask

  task automatic cyc(input logic iv, input logic [31:0] w, input logic [31:0] pc,
                     input logic [31:0] rsv, input logic b);
    instr_valid = iv; instr_word = w; instr_pc = pc; rs_value = rsv; sys_wr_busy = b;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  // issue one jump, then idle until the redirect has left
  task automatic jump(input logic [4:0] rt, input logic [4:0] rs, input logic [31:0] pc,
                      input logic [31:0] tgt);
    cyc(1, enc(rt, rs), pc, tgt, 0);
    cyc(0, 32'h0, 32'h0, 32'hDEAD_BEEF, 0);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1;
    @(negedge clk);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);
    rst = 0;
    cyc(0, 32'h0, 32'h0, 32'h0, 0);           // reset state

    jump(5'd5, 5'd3, 32'h0000_1000, 32'h1000_0001);  // odd target, R6
    jump(5'd7, 5'd4, 32'h0000_2000, 32'h2000_0000);  // even aligned, R7 clean / R8 error
    jump(5'd9, 5'd8, 32'h0000_3000, 32'h2000_0002);  // bit1 set, R7 error
    jump(5'd9, 5'd8, 32'h0000_3004, 32'h2000_0003);  // bit1 set, odd: no error
    jump(5'd0, 5'd31, 32'h0000_4000, 32'h3000_0005); // R3 rt zero
    // R4: rt equals rs, register value changes after issue
    cyc(1, enc(5'd6, 5'd6), 32'h0000_5000, 32'h4444_0011, 0);
    cyc(0, 32'h0, 32'h0, 32'h0000_5004, 0);
    cyc(0, 32'h0, 32'h0, 32'h0000_5004, 0);

    // R1: each fixed field wrong in turn
    cyc(1, enc(5'd2, 5'd3) | 32'h0400_0000, 32'h100, 32'h1, 0);
    cyc(1, enc(5'd2, 5'd3) ^ 32'h0000_0040, 32'h104, 32'h1, 0);
    cyc(1, enc(5'd2, 5'd3) ^ 32'h0000_0001, 32'h108, 32'h1, 0);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);

    // R9/R10/R11: busy held, instruction offered during wait, another at release
    cyc(1, enc(5'd10, 5'd11), 32'h0000_6000, 32'h5000_0009, 1);
    for (int n = 0; n < 5; n++) cyc(0, 32'h0, 32'h0, 32'h0, 1);
    cyc(1, enc(5'd12, 5'd13), 32'h0000_7000, 32'h6000_0001, 1); // ignored
    cyc(0, 32'h0, 32'h0, 32'h0, 0);                               // busy sampled low
    cyc(1, enc(5'd14, 5'd15), 32'h0000_8000, 32'h7000_0002, 1);  // redirect cycle, accepted
    cyc(0, 32'h0, 32'h0, 32'h0, 1);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);

    // back-to-back: invalid word while waiting is also ignored
    cyc(1, enc(5'd1, 5'd2), 32'h0000_9000, 32'h0000_0004, 1);
    cyc(1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);
    cyc(0, 32'h0, 32'h0, 32'h0, 0);

    finish_run();
  end
endmodule